// File: doc/BRIEF.md
# PHY Initialisation Script Sequencer

This block brings a network PHY into a known state and then programs it from a script kept in a word-addressed memory. On a start pulse it latches the module type it is asked to serve. It then soft-resets the PHY through a register request port and polls until the reset bit self-clears. Next it follows a pointer held at a fixed memory word to a lookup table of (module type, script offset) pairs, and from there finds the script for the latched type.

The script is a stream of 16-bit words. Each word carries a 4-bit kind and a 12-bit argument. The kinds are a millisecond pause, a burst of writes to consecutive PHY registers, and start/end markers. The block steps through the script until the end marker or an error. It then gives a one-cycle completion pulse with a 3-bit result code.

Both external ports use a request/acknowledge pair. A request stays high until it is acknowledged, and only one request is outstanding at a time.

Top module: `phyinit_seq`

## Requirements
- R1: After an accepted start, the block reads PHY register CTRL_REG. It then writes the same value back to that register with bit 15 (the soft-reset bit) set.
- R2: After that write, the block reads CTRL_REG repeatedly until bit 15 reads 0, and makes at most POLL_MAX such reads (100 by default). If bit 15 is still 1 on the last permitted read, the run ends with status 3 and no memory read takes place.
- R3: The table pointer is read from memory word LIST_PTR_ADDR. A value of 0x0000 or 0xFFFF ends the run with status 1.
- R4: Table entries are word pairs (module type, script offset), starting one word after the pointer value. Each type word is compared with the latched module type. A type word of 0xFFFF ends the scan with status 2.
- R5: A matching entry whose offset word is 0x0000 or 0xFFFF ends the run with status 2.
- R6: The word at the script offset is skipped, and execution starts at the next word. A word's kind is in bits [15:12] and its argument in bits [11:0]. Kind 0x0 pauses for argument × CYC_PER_MS clock cycles and issues no request during the pause; an argument of 0 gives no pause.
- R7: Kind 0x1 takes the next word as a PHY register number R. The following N words (N = the argument) are then written to registers R, R+1, … R+N−1 in order. With N = 0, no write is issued.
- R8: Kind 0xF with argument 0xFFF ends the run with status 0. Kind 0xF with argument 0x000 is a start marker, and execution carries on with the next word.
- R9: Kind 0xF with any other argument, or any kind other than 0x0, 0x1 and 0xF, ends the run with status 4, and no later script word is acted on.
- R10: `done` is high for exactly one cycle per run. `status` holds the result until the next run ends. `busy` is high from the cycle after an accepted start until `done`. A start pulse while busy is ignored.
- R11: A request (`mem_req` or `phy_req`) stays high with stable address and data until the cycle its acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled only while idle) |
| module_id | input | 16 | Module type to look up, latched at start |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_ack | input | 1 | Memory acknowledge, data valid with it |
| mem_rdata | input | 16 | Memory read data |
| phy_req | output | 1 | PHY register access request |
| phy_wr | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register number |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY acknowledge, read data valid with it |
| phy_rdata | input | 16 | PHY read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 no script, 2 unsupported module, 3 reset timeout, 4 bad script word |

## Verification
The hardest case to reach from the ports is the reset timeout. It needs a PHY whose reset bit never clears, so that the block must count exactly POLL_MAX reads and then give up without touching memory. The bench PHY model holds the bit set for a programmed number of reads. A sweep of that number covers the normal exits, and a value far beyond the limit forces the timeout; both the read count and the absence of memory traffic are checked. Pause lengths are checked as the cycle difference between otherwise identical runs, so the handshake latency cancels out.

// File: rtl/phyinit_pkg.sv
package phyinit_pkg;
  localparam int WORD_W = 16;
  localparam int ARG_W  = 12;

  typedef enum logic [2:0] {
    ST_OK          = 3'd0,
    ST_NO_SCRIPT   = 3'd1,
    ST_UNSUPPORTED = 3'd2,
    ST_RST_TIMEOUT = 3'd3,
    ST_BAD_WORD    = 3'd4
  } init_status_e;

  typedef enum logic [2:0] {
    K_PAUSE, K_BURST, K_MARK_START, K_MARK_END, K_ILLEGAL
  } word_kind_e;

  localparam logic [3:0]        KIND_PAUSE = 4'h0;
  localparam logic [3:0]        KIND_BURST = 4'h1;
  localparam logic [3:0]        KIND_MARK  = 4'hF;
  localparam logic [ARG_W-1:0]  MARK_END   = 12'hFFF;
  localparam logic [ARG_W-1:0]  MARK_START = 12'h000;
  localparam logic [WORD_W-1:0] TABLE_END  = 16'hFFFF;
endpackage

// File: rtl/phyinit_decode.sv
module phyinit_decode
  import phyinit_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output word_kind_e        kind,
  output logic [ARG_W-1:0]  arg
);
  logic [3:0] kfield;
  assign kfield = word[WORD_W-1:ARG_W];
  assign arg    = word[ARG_W-1:0];

  always_comb begin
    unique case (kfield)
      KIND_PAUSE: kind = K_PAUSE;
      KIND_BURST: kind = K_BURST;
      KIND_MARK: begin
        if (arg == MARK_END)        kind = K_MARK_END;
        else if (arg == MARK_START) kind = K_MARK_START;
        else                        kind = K_ILLEGAL;
      end
      default: kind = K_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/phyinit_ms_timer.sv
module phyinit_ms_timer
  import phyinit_pkg::*;
#(
  parameter int CYC_PER_MS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ARG_W-1:0] ms_in,
  output logic             expired
);
  localparam int SW = $clog2(CYC_PER_MS + 1);

  logic [ARG_W-1:0] ms_q, ms_n;
  logic [SW-1:0]    sub_q, sub_n;

  always_comb begin
    ms_n  = ms_q;
    sub_n = sub_q;
    if (load) begin
      ms_n  = ms_in;
      sub_n = '0;
    end else if (ms_q != '0) begin
      if (sub_q == SW'(CYC_PER_MS - 1)) begin
        sub_n = '0;
        ms_n  = ms_q - 1'b1;
      end else begin
        sub_n = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sub_q <= '0;
    end else begin
      ms_q  <= ms_n;
      sub_q <= sub_n;
    end
  end

  assign expired = (ms_q == '0);

  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired); // R6
endmodule

// File: rtl/phyinit_seq.sv
module phyinit_seq
  import phyinit_pkg::*;
#(
  parameter int              AW            = 16,
  parameter logic [AW-1:0]   LIST_PTR_ADDR = 16'h0002,
  parameter logic [15:0]     CTRL_REG      = 16'h0000,
  parameter int              RST_BIT       = 15,
  parameter int              POLL_MAX      = 100,
  parameter int              CYC_PER_MS    = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   module_id,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          phy_req,
  output logic          phy_wr,
  output logic [15:0]   phy_addr,
  output logic [15:0]   phy_wdata,
  input  logic          phy_ack,
  input  logic [15:0]   phy_rdata,
  output logic          busy,
  output logic          done,
  output logic [2:0]    status
);
  localparam int PCW = $clog2(POLL_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_RD, S_RST_WR, S_POLL, S_PTR, S_ID, S_OFS,
    S_FETCH, S_REGNUM, S_DATA, S_WRITE, S_PAUSE
  } seq_state_e;

  seq_state_e       state_q, state_n;
  logic [AW-1:0]    ptr_q, ptr_n;
  logic [ARG_W-1:0] cnt_q, cnt_n;
  logic [15:0]      reg_q, reg_n;
  logic [15:0]      wdata_q, wdata_n;
  logic [15:0]      mid_q, mid_n;
  logic [PCW-1:0]   poll_q, poll_n;
  init_status_e     status_q, status_n, code;
  logic             done_q, done_n, fin;
  logic             tmr_load, tmr_expired;
  word_kind_e       kind;
  logic [ARG_W-1:0] arg;
  logic             rdata_void;

  phyinit_decode u_dec (.word(mem_rdata), .kind(kind), .arg(arg));

  phyinit_ms_timer #(.CYC_PER_MS(CYC_PER_MS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .ms_in(arg), .expired(tmr_expired)
  );

  assign rdata_void = (mem_rdata == 16'h0000) || (mem_rdata == 16'hFFFF);

  always_comb begin
    state_n  = state_q;
    ptr_n    = ptr_q;
    cnt_n    = cnt_q;
    reg_n    = reg_q;
    wdata_n  = wdata_q;
    mid_n    = mid_q;
    poll_n   = poll_q;
    fin      = 1'b0;
    code     = ST_OK;
    tmr_load = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        mid_n   = module_id;
        state_n = S_RST_RD;
      end
      S_RST_RD: if (phy_ack) begin
        wdata_n = phy_rdata | (16'h0001 << RST_BIT);
        state_n = S_RST_WR;
      end
      S_RST_WR: if (phy_ack) begin
        poll_n  = '0;
        state_n = S_POLL;
      end
      S_POLL: if (phy_ack) begin
        if (!phy_rdata[RST_BIT]) begin
          ptr_n   = LIST_PTR_ADDR;
          state_n = S_PTR;
        end else if (poll_q == PCW'(POLL_MAX - 1)) begin
          fin  = 1'b1;
          code = ST_RST_TIMEOUT;
        end else begin
          poll_n = poll_q + 1'b1;
        end
      end
      S_PTR: if (mem_ack) begin
        if (rdata_void) begin
          fin  = 1'b1;
          code = ST_NO_SCRIPT;
        end else begin
          ptr_n   = AW'(mem_rdata) + 1'b1;
          state_n = S_ID;
        end
      end
      S_ID: if (mem_ack) begin
        if (mem_rdata == TABLE_END) begin
          fin  = 1'b1;
          code = ST_UNSUPPORTED;
        end else if (mem_rdata == mid_q) begin
          ptr_n   = ptr_q + 1'b1;
          state_n = S_OFS;
        end else begin
          ptr_n = ptr_q + AW'(2);
        end
      end
      S_OFS: if (mem_ack) begin
        if (rdata_void) begin
          fin  = 1'b1;
          code = ST_UNSUPPORTED;
        end else begin
          ptr_n   = AW'(mem_rdata) + 1'b1;
          state_n = S_FETCH;
        end
      end
      S_FETCH: if (mem_ack) begin
        ptr_n = ptr_q + 1'b1;
        unique case (kind)
          K_PAUSE: begin
            tmr_load = 1'b1;
            state_n  = S_PAUSE;
          end
          K_BURST: begin
            cnt_n   = arg;
            state_n = S_REGNUM;
          end
          K_MARK_START: state_n = S_FETCH;
          K_MARK_END: begin
            fin  = 1'b1;
            code = ST_OK;
          end
          default: begin
            fin  = 1'b1;
            code = ST_BAD_WORD;
          end
        endcase
      end
      S_PAUSE: if (tmr_expired) state_n = S_FETCH;
      S_REGNUM: if (mem_ack) begin
        ptr_n   = ptr_q + 1'b1;
        reg_n   = mem_rdata;
        state_n = (cnt_q == '0) ? S_FETCH : S_DATA;
      end
      S_DATA: if (mem_ack) begin
        ptr_n   = ptr_q + 1'b1;
        wdata_n = mem_rdata;
        state_n = S_WRITE;
      end
      S_WRITE: if (phy_ack) begin
        reg_n   = reg_q + 1'b1;
        cnt_n   = cnt_q - 1'b1;
        state_n = (cnt_q == ARG_W'(1)) ? S_FETCH : S_DATA;
      end
      default: state_n = S_IDLE;
    endcase
    if (fin) state_n = S_IDLE;
    done_n   = fin;
    status_n = fin ? code : status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ptr_q    <= '0;
      cnt_q    <= '0;
      reg_q    <= '0;
      wdata_q  <= '0;
      mid_q    <= '0;
      poll_q   <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      state_q  <= state_n;
      ptr_q    <= ptr_n;
      cnt_q    <= cnt_n;
      reg_q    <= reg_n;
      wdata_q  <= wdata_n;
      mid_q    <= mid_n;
      poll_q   <= poll_n;
      done_q   <= done_n;
      status_q <= status_n;
    end
  end

  assign mem_req   = (state_q == S_PTR) || (state_q == S_ID) || (state_q == S_OFS) ||
                     (state_q == S_FETCH) || (state_q == S_REGNUM) || (state_q == S_DATA);
  assign mem_addr  = ptr_q;
  assign phy_req   = (state_q == S_RST_RD) || (state_q == S_RST_WR) ||
                     (state_q == S_POLL) || (state_q == S_WRITE);
  assign phy_wr    = (state_q == S_RST_WR) || (state_q == S_WRITE);
  assign phy_addr  = (state_q == S_WRITE) ? reg_q : CTRL_REG;
  assign phy_wdata = wdata_q;
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign status    = status_q;

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R11
  AST_PHY_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req && $stable(phy_addr) && $stable(phy_wdata) && $stable(phy_wr)); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R10
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q < PCW'(POLL_MAX)); // R2
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PAUSE) && !tmr_expired |=> !mem_req && !phy_req); // R6
endmodule

// File: tb/phyinit_seq_tb.sv
module phyinit_seq_tb_top;
  localparam int CYC = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] module_id;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr, mem_rdata;
  logic        phy_req, phy_wr, phy_ack;
  logic [15:0] phy_addr, phy_wdata, phy_rdata;
  logic        busy, done;
  logic [2:0]  status;

  phyinit_seq #(.LIST_PTR_ADDR(16'h0002), .POLL_MAX(100), .CYC_PER_MS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .module_id(module_id),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .phy_req(phy_req), .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata),
    .busy(busy), .done(done), .status(status)
  );

  logic [15:0] mem [256];
  logic [15:0] wr_addr [64];
  logic [15:0] wr_data [64];
  logic [15:0] ctrl_val, ctrl_wval;
  int wr_n, ctrl_rd_n, mem_rd_n, done_n, clr_after, pend, cyc;
  int checks = 0;
  int errors = 0;

  initial forever #5 clk = ~clk;
  initial begin cyc = 0; forever begin @(posedge clk); cyc++; end end

  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(posedge clk); #1;
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1; mem_rdata = mem[mem_addr[7:0]]; mem_rd_n++;
      end else mem_ack = 1'b0;
    end
  end

  initial begin
    phy_ack = 1'b0; phy_rdata = '0;
    forever begin
      @(posedge clk); #1;
      if (phy_req && !phy_ack) begin
        phy_ack = 1'b1;
        if (phy_wr) begin
          if (phy_addr == 16'h0) begin
            ctrl_val = phy_wdata; ctrl_wval = phy_wdata; pend = clr_after;
          end else if (wr_n < 64) begin
            wr_addr[wr_n] = phy_addr; wr_data[wr_n] = phy_wdata; wr_n++;
          end
        end else if (phy_addr == 16'h0) begin
          ctrl_rd_n++;
          if (pend > 0) begin pend--; phy_rdata = ctrl_val | 16'h8000; end
          else phy_rdata = ctrl_val & 16'h7FFF;
        end else phy_rdata = 16'h0;
      end else phy_ack = 1'b0;
    end
  end

  initial forever begin @(negedge clk); if (done) done_n++; end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not end, act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic std_layout();
    int p;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[2] = 16'd16;
    for (int k = 0; k < 4; k++) begin
      mem[17 + 2*k] = 16'h0100 + 16'(k);
      mem[18 + 2*k] = 16'(64 + 32*k);
      p = 64 + 32*k;
      mem[p] = 16'hC5C5; p++;
      mem[p] = 16'hF000; p++;
      mem[p] = 16'h1000 | 16'(k); p++;
      mem[p] = 16'h0010 * 16'(k + 1); p++;
      for (int i = 0; i < k; i++) begin mem[p] = 16'h5000 + 16'(16*k + i); p++; end
      mem[p] = 16'hFFFF;
    end
    mem[25] = 16'h0200; mem[26] = 16'd200; mem[27] = 16'hFFFF;
    mem[200] = 16'h1234; mem[201] = 16'h0000; mem[202] = 16'hFFFF;
  endtask

  task automatic run(input logic [15:0] id, input bit extra, output int st, output int cycles);
    int n, t0;
    wr_n = 0; ctrl_rd_n = 0; mem_rd_n = 0; done_n = 0; ctrl_val = 16'h0140; pend = 0;
    @(negedge clk); module_id = id; start = 1'b1; t0 = cyc;
    @(negedge clk); start = 1'b0; n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      if (extra && n == 8) begin start = 1'b1; module_id = 16'h0100; end
      else start = 1'b0;
    end
    st = int'(status); cycles = cyc - t0;
    if (n >= 20000) begin errors++; $display("FAIL R10 no done act=none exp=pulse"); end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int st, cy, c0;
    rst_n = 1'b0; start = 1'b0; module_id = '0; clr_after = 0;
    wr_n = 0; ctrl_rd_n = 0; mem_rd_n = 0; done_n = 0; pend = 0; ctrl_val = 16'h0140;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R11 reset mem_req", int'(mem_req), 0);
    chk("R11 reset phy_req", int'(phy_req), 0);

    // R7 R8 R1: bursts of length 0..3 selected by module id
    for (int k = 0; k < 4; k++) begin
      std_layout();
      run(16'h0100 + 16'(k), 1'b0, st, cy);
      chk("R8 status ok", st, 0);
      chk("R1 reset write value", int'(ctrl_wval), 16'h8140);
      chk("R2 single poll", ctrl_rd_n, 2);
      chk("R7 write count", wr_n, k);
      for (int i = 0; i < k; i++) begin
        chk("R7 write addr", int'(wr_addr[i]), 16*(k+1) + i);
        chk("R7 write data", int'(wr_data[i]), 16'h5000 + 16*k + i);
      end
      chk("R10 one done", done_n, 1);
    end

    // R2: reset bit clears after n extra reads
    for (int n = 0; n < 4; n++) begin
      std_layout(); clr_after = n;
      run(16'h0101, 1'b0, st, cy);
      chk("R2 poll reads", ctrl_rd_n, n + 2);
      chk("R2 status", st, 0);
    end
    clr_after = 1000;
    run(16'h0101, 1'b0, st, cy);
    chk("R2 timeout status", st, 3);
    chk("R2 timeout poll reads", ctrl_rd_n, 101);
    chk("R2 no mem read", mem_rd_n, 0);
    clr_after = 0;

    // R3
    std_layout(); mem[2] = 16'h0000;
    run(16'h0100, 1'b0, st, cy);
    chk("R3 zero ptr", st, 1);
    chk("R3 one mem read", mem_rd_n, 1);
    mem[2] = 16'hFFFF;
    run(16'h0100, 1'b0, st, cy);
    chk("R3 all-ones ptr", st, 1);

    // R4 R5
    std_layout();
    run(16'h0300, 1'b0, st, cy);
    chk("R4 no match", st, 2);
    chk("R4 table reads", mem_rd_n, 1 + 5 + 1);
    chk("R4 no writes", wr_n, 0);
    mem[18] = 16'h0000;
    run(16'h0100, 1'b0, st, cy);
    chk("R5 zero offset", st, 2);
    mem[18] = 16'hFFFF;
    run(16'h0100, 1'b0, st, cy);
    chk("R5 all-ones offset", st, 2);

    // R6: pause length as cycle difference
    std_layout();
    run(16'h0200, 1'b0, st, c0);
    chk("R6 zero pause status", st, 0);
    for (int d = 1; d < 4; d++) begin
      mem[201] = 16'(d);
      run(16'h0200, 1'b0, st, cy);
      chk("R6 status", st, 0);
      chk("R6 pause cycles", cy - c0, d * CYC);
    end

    // R9: illegal kinds and marker arguments
    for (int t = 2; t < 15; t++) begin
      std_layout(); mem[201] = 16'(t << 12) | 16'h0003;
      run(16'h0200, 1'b0, st, cy);
      chk("R9 illegal kind", st, 4);
    end
    std_layout(); mem[201] = 16'hF001;
    run(16'h0200, 1'b0, st, cy);
    chk("R9 bad marker 001", st, 4);
    mem[201] = 16'hFFFE;
    run(16'h0200, 1'b0, st, cy);
    chk("R9 bad marker FFE", st, 4);
    mem[201] = 16'h1001; mem[202] = 16'h0030; mem[203] = 16'hABCD;
    mem[204] = 16'hF123; mem[205] = 16'h1001; mem[206] = 16'h0040; mem[207] = 16'h1111;
    mem[208] = 16'hFFFF;
    run(16'h0200, 1'b0, st, cy);
    chk("R9 stop status", st, 4);
    chk("R9 writes before stop", wr_n, 1);
    chk("R9 written data", int'(wr_data[0]), 16'hABCD);

    // R10: start while busy is ignored
    std_layout();
    run(16'h0103, 1'b1, st, cy);
    repeat (30) @(negedge clk);
    chk("R10 single done", done_n, 1);
    chk("R10 idle after", int'(busy), 0);
    chk("R10 first run kept", wr_n, 3);
    chk("R10 status held", int'(status), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule